// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block drives an external analog-to-digital converter through a programmable list of channel slots. Software loads up to eight 3-bit channel numbers and a last-slot index, then pulses start while the engine is enabled. For each slot the sequencer raises a conversion request with the channel number and waits for the converter's acknowledge. It then writes the returned sample, tagged with its channel, into a 32-entry result FIFO. Between two conversions it waits a programmable number of timebase ticks.

In single mode one pass through the list ends the run. In continuous mode the slot index wraps to the first slot until software pulses stop. A stop never abandons a conversion already requested: its result is stored before the block goes idle. Software reads tagged entries through a read strobe. It watches three busy flags, the fill level, the full, empty and sticky overflow flags, and a level interrupt raised when the fill level reaches a threshold.

Top module: `adc_seq`

## Requirements
- R1: After reset all busy flags, `conv_req`, `fifo_full`, `fifo_overflow` and `irq` are 0, `fifo_empty` is 1, and `fifo_count` and `rd_data` are 0.
- R2: A start pulse while `eng_enable` is 0 is ignored: no request is issued and `busy_run` stays 0.
- R3: `busy_run` is 1 in the first cycle after an accepted start pulse and stays 1 until the run ends. `busy_conv` is 1 while a request is outstanding, and `busy_wait` is 1 during the inter-sample delay.
- R4: Requests visit slots 0, 1, ... up to `last_index`, so a pass covers `last_index`+1 slots. Slot i is `slot_list[3i+2:3i]`, and `conv_chan` holds that value, stable until the acknowledge.
- R5: With `cont_mode` 0 the run ends after the conversion of slot `last_index`. With `cont_mode` 1 the next slot after `last_index` is slot 0.
- R6: A stop pulse ends the run. An outstanding request is completed and its result stored before `busy_run` falls. A stop during the delay ends the run on the next clock. No further request follows.
- R7: Between two consecutive requests of a run, `conv_req` is low for exactly (`delay_count`+1) ticks. A tick is one clock when `tick_sel` is 0, and one tick every PRESCALE (4) clocks, counted from the acknowledge, when `tick_sel` is 1.
- R8: Each FIFO entry has the channel in bits 14:12 and the 12-bit sample in bits 11:0. Entries leave in arrival order, and `rd_data` shows the entry in the cycle after `rd_en`.
- R9: `fifo_count` gives the number of stored entries modulo 32. With 32 entries it reads 0, `fifo_full` is 1 and `fifo_empty` is 0.
- R10: A result arriving while the FIFO is full and no read is made in that cycle is dropped and sets `fifo_overflow`, which stays set until reset. A result arriving in the same cycle as a read of a full FIFO is stored.
- R11: A read of an empty FIFO returns 0 on `rd_data` and leaves the count at 0.
- R12: `irq` equals `irq_enable` AND (fill level >= `irq_level`), one clock after the fill level changes. The fill level runs 0 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_enable | input | 1 | Engine enable; start pulses are accepted only while set |
| cont_mode | input | 1 | 1: wrap to slot 0 after the last slot; 0: single pass |
| start_pulse | input | 1 | One-cycle start request |
| stop_pulse | input | 1 | One-cycle stop request |
| slot_list | input | 24 | Eight 3-bit channel numbers, slot i at bits 3i+2:3i |
| last_index | input | 3 | Index of the last active slot |
| delay_count | input | 8 | Inter-sample delay N; the delay is N+1 ticks |
| tick_sel | input | 1 | Timebase: 0 every clock, 1 every PRESCALE clocks |
| irq_enable | input | 1 | Interrupt enable |
| irq_level | input | 5 | Fill-level threshold for the interrupt |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 3 | Channel to convert |
| conv_ack | input | 1 | Converter acknowledge; `conv_data` is valid with it |
| conv_data | input | 12 | Converted sample |
| rd_en | input | 1 | FIFO read strobe |
| rd_data | output | 15 | Read entry: channel 14:12, sample 11:0 |
| fifo_count | output | 5 | Fill level modulo 32 |
| fifo_full | output | 1 | FIFO holds 32 entries |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_overflow | output | 1 | Sticky: a result was dropped |
| busy_run | output | 1 | A run is active |
| busy_conv | output | 1 | A conversion request is outstanding |
| busy_wait | output | 1 | The inter-sample delay is running |
| irq | output | 1 | Fill-level interrupt |

## Verification
A result push and a software read can fall in the same clock, and the case that matters is when the FIFO is already full. The bench first fills the FIFO past overflow in continuous mode. It then restarts a run and, at each cycle where the acknowledge is visible, raises `rd_en` for that same clock edge. A model queue in the bench pops before it pushes, and the drained contents must show the three reads returning the oldest entries and the three new results stored behind the older ones, with `fifo_full` still set.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_t;

endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DATA_W = 15,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [AW:0]       fill,
  output logic              full,
  output logic              empty,
  output logic              overflow
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [DATA_W-1:0] rd_q;
  logic              rd_zero;
  logic              do_pop, do_push;

  assign full    = (fill == (AW+1)'(DEPTH));
  assign empty   = (fill == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  // storage without reset so that a block RAM can be inferred (read-first)
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
    if (pop)     rd_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      fill     <= '0;
      rd_zero  <= 1'b1;
      overflow <= 1'b0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      if (pop)     rd_zero <= empty;
      if (push && !do_push) overflow <= 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign rd_data = rd_zero ? '0 : rd_q;

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (rst)
    fill <= (AW+1)'(DEPTH));

  p_full_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (overflow && full));

  p_empty_read_r11: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (empty && rd_data == '0));

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int DLY_W    = 8,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] count_in,
  input  logic             tick_sel,
  output logic             running,
  output logic             done
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [DLY_W-1:0] cnt;
  logic             slow_tick;
  logic             tick;

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst || load)
          pre <= '0;
        else if (running)
          pre <= slow_tick ? '0 : pre + 1'b1;
      end
      assign slow_tick = (pre == PRE_W'(PRESCALE - 1));
    end else begin : g_nopre
      assign slow_tick = 1'b1;
    end
  endgenerate

  assign tick = tick_sel ? slow_tick : 1'b1;
  assign done = running && tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (load) begin
      running <= 1'b1;
      cnt     <= count_in;
    end else if (running && tick) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  p_done_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> !running);

  p_fast_count_r7: assert property (@(posedge clk) disable iff (rst)
    (running && !load && !tick_sel && cnt != '0) |=> (running && cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int CH_W   = 3,
  parameter int DATA_W = 12,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  input  logic                  continuous,
  input  logic                  start,
  input  logic                  stop,
  input  logic [SLOTS*CH_W-1:0] slot_list,
  input  logic [IDX_W-1:0]      last_idx,
  output logic                  conv_req,
  output logic [CH_W-1:0]       conv_chan,
  input  logic                  conv_ack,
  input  logic [DATA_W-1:0]     conv_data,
  output logic                  push,
  output logic [CH_W+DATA_W-1:0] push_data,
  output logic                  tmr_load,
  input  logic                  tmr_done,
  output logic                  busy_run,
  output logic                  busy_conv,
  output logic                  busy_wait
);
  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_next;
  logic             stop_pend;
  logic             at_last;
  logic             ending;

  assign at_last   = (idx >= last_idx);
  assign idx_next  = at_last ? '0 : idx + 1'b1;
  assign ending    = stop || stop_pend || (at_last && !continuous);

  assign conv_req  = (state == ST_REQ);
  assign busy_conv = (state == ST_REQ);
  assign busy_wait = (state == ST_WAIT);
  assign busy_run  = (state != ST_IDLE);

  assign push      = conv_req && conv_ack;
  assign tmr_load  = push;
  assign push_data = {conv_chan, conv_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      conv_chan <= '0;
      stop_pend <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          stop_pend <= 1'b0;
          if (start && enable) begin
            state     <= ST_REQ;
            idx       <= '0;
            conv_chan <= slot_list[CH_W-1:0];
          end
        end
        ST_REQ: begin
          if (stop) stop_pend <= 1'b1;
          if (conv_ack) begin
            if (ending) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
              idx   <= idx_next;
            end
          end
        end
        ST_WAIT: begin
          if (stop || stop_pend) begin
            state <= ST_IDLE;
          end else if (tmr_done) begin
            state     <= ST_REQ;
            conv_chan <= slot_list[idx*CH_W +: CH_W];
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_run && start && enable) |=> (busy_run && conv_req));

  p_disabled_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_run && !enable) |=> !busy_run);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_ack) |=> (conv_req && $stable(conv_chan)));

  p_wait_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_wait && stop) |=> !busy_run);

  p_single_end_r5: assert property (@(posedge clk) disable iff (rst)
    (push && at_last && !continuous) |=> !busy_run);

endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int SLOTS    = 8,
  parameter int CH_W     = 3,
  parameter int DATA_W   = 12,
  parameter int FIFO_AW  = 5,
  parameter int DLY_W    = 8,
  parameter int PRESCALE = 4,
  localparam int IDX_W   = $clog2(SLOTS),
  localparam int ENTRY_W = CH_W + DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  eng_enable,
  input  logic                  cont_mode,
  input  logic                  start_pulse,
  input  logic                  stop_pulse,
  input  logic [SLOTS*CH_W-1:0] slot_list,
  input  logic [IDX_W-1:0]      last_index,
  input  logic [DLY_W-1:0]      delay_count,
  input  logic                  tick_sel,
  input  logic                  irq_enable,
  input  logic [FIFO_AW-1:0]    irq_level,
  output logic                  conv_req,
  output logic [CH_W-1:0]       conv_chan,
  input  logic                  conv_ack,
  input  logic [DATA_W-1:0]     conv_data,
  input  logic                  rd_en,
  output logic [ENTRY_W-1:0]    rd_data,
  output logic [FIFO_AW-1:0]    fifo_count,
  output logic                  fifo_full,
  output logic                  fifo_empty,
  output logic                  fifo_overflow,
  output logic                  busy_run,
  output logic                  busy_conv,
  output logic                  busy_wait,
  output logic                  irq
);
  logic               push;
  logic [ENTRY_W-1:0] push_data;
  logic               tmr_load, tmr_done, tmr_running;
  logic [FIFO_AW:0]   fill;

  adc_seq_ctrl #(
    .SLOTS(SLOTS), .CH_W(CH_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .enable(eng_enable), .continuous(cont_mode),
    .start(start_pulse), .stop(stop_pulse), .slot_list(slot_list),
    .last_idx(last_index), .conv_req(conv_req), .conv_chan(conv_chan),
    .conv_ack(conv_ack), .conv_data(conv_data), .push(push),
    .push_data(push_data), .tmr_load(tmr_load), .tmr_done(tmr_done),
    .busy_run(busy_run), .busy_conv(busy_conv), .busy_wait(busy_wait)
  );

  adc_seq_timer #(
    .DLY_W(DLY_W), .PRESCALE(PRESCALE)
  ) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .count_in(delay_count),
    .tick_sel(tick_sel), .running(tmr_running), .done(tmr_done)
  );

  adc_seq_fifo #(
    .DATA_W(ENTRY_W), .AW(FIFO_AW)
  ) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .pop(rd_en), .rd_data(rd_data), .fill(fill), .full(fifo_full),
    .empty(fifo_empty), .overflow(fifo_overflow)
  );

  assign fifo_count = fill[FIFO_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_enable && (fill >= {1'b0, irq_level});
  end

  p_irq_gate_r12: assert property (@(posedge clk) disable iff (rst)
    !irq_enable |=> !irq);

  p_timer_in_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_wait && !stop_pulse && !tmr_running) |=> !busy_wait);

endmodule

// File: tb/adc_seq_test.sv
module adc_seq_test;
  localparam int PRE = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        eng_enable = 1'b0, cont_mode = 1'b0, start_pulse = 1'b0, stop_pulse = 1'b0;
  logic [23:0] slot_list = '0;
  logic [2:0]  last_index = '0;
  logic [7:0]  delay_count = 8'd10;
  logic        tick_sel = 1'b0, irq_enable = 1'b0;
  logic [4:0]  irq_level = '0;
  logic        conv_req;
  logic [2:0]  conv_chan;
  logic        conv_ack;
  logic [11:0] conv_data;
  logic        rd_en = 1'b0;
  logic [14:0] rd_data;
  logic [4:0]  fifo_count;
  logic        fifo_full, fifo_empty, fifo_overflow;
  logic        busy_run, busy_conv, busy_wait, irq;

  adc_seq uut (
    .clk(clk), .rst(rst), .eng_enable(eng_enable), .cont_mode(cont_mode),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .slot_list(slot_list),
    .last_index(last_index), .delay_count(delay_count), .tick_sel(tick_sel),
    .irq_enable(irq_enable), .irq_level(irq_level), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_ack(conv_ack), .conv_data(conv_data),
    .rd_en(rd_en), .rd_data(rd_data), .fifo_count(fifo_count),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_overflow(fifo_overflow),
    .busy_run(busy_run), .busy_conv(busy_conv), .busy_wait(busy_wait), .irq(irq)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] data_of(input int n);
    return 12'((n * 149 + 7) % 4096);
  endfunction

  function automatic logic [23:0] make_slots(input int mul, input int add);
    logic [23:0] s;
    for (int i = 0; i < 8; i++) s[i*3 +: 3] = 3'((i * mul + add) % 8);
    return s;
  endfunction

  // converter stub and expected FIFO contents
  int          lat_cfg = 2, lat_cnt = 0, n_ack = 0, run_idx = 0, cur_last = 0;
  logic [23:0] cur_slots = '0;
  logic [14:0] q[$];
  logic [14:0] exp_rd = '0;
  logic [2:0]  pchan;
  bit          popped;

  always @(posedge clk) begin
    if (rst) begin
      conv_ack <= 1'b0;
      conv_data <= '0;
      lat_cnt = 0;
    end else begin
      popped = 0;
      if (rd_en) begin
        if (q.size() > 0) begin exp_rd = q.pop_front(); popped = 1; end
        else exp_rd = '0;
      end
      if (conv_ack) begin
        pchan = cur_slots[run_idx*3 +: 3];
        chk(conv_chan == pchan, "R4", "requested channel", conv_chan, pchan);
        if (q.size() < 32) q.push_back({pchan, data_of(n_ack)});
        n_ack++;
        run_idx = (run_idx >= cur_last) ? 0 : run_idx + 1;
        conv_ack <= 1'b0;
      end else if (conv_req) begin
        if (lat_cnt >= lat_cfg - 1) begin
          conv_ack  <= 1'b1;
          conv_data <= data_of(n_ack);
          lat_cnt = 0;
        end else lat_cnt++;
      end
    end
  end

  // request monitor and same-cycle read driver
  int req_rises = 0, gap = 0, last_gap = 0, sim_left = 0;
  bit req_prev = 0, sim_mode = 0, sim_pend = 0;

  always @(negedge clk) begin
    if (conv_req && !req_prev) begin
      req_rises++;
      if (gap > 0) last_gap = gap;
    end
    if (conv_req) gap = 0;
    else if (busy_run) gap++;
    req_prev = conv_req;
    if (sim_mode) begin
      if (sim_pend) begin
        chk(rd_data == exp_rd, "R10", "read in push cycle", rd_data, exp_rd);
        sim_pend = 0;
      end
      if (conv_ack && sim_left > 0) begin
        rd_en = 1'b1; sim_left--; sim_pend = 1;
      end else rd_en = 1'b0;
    end
  end

  task automatic start_run(input logic [23:0] s, input int last, input bit cont,
                           input int n, input bit tsel);
    @(negedge clk);
    slot_list = s; last_index = 3'(last); cont_mode = cont;
    delay_count = 8'(n); tick_sel = tsel;
    cur_slots = s; cur_last = last; run_idx = 0;
    start_pulse = 1'b1;
    @(negedge clk);
    start_pulse = 1'b0;
    chk(busy_run == 1'b1, "R3", "busy_run after start", busy_run, 1);
    chk(busy_conv == 1'b1, "R3", "busy_conv after start", busy_conv, 1);
  endtask

  task automatic wait_idle();
    while (busy_run) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_stop();
    stop_pulse = 1'b1;
    @(negedge clk);
    stop_pulse = 1'b0;
  endtask

  task automatic check_level(input string req);
    int sz;
    sz = q.size();
    chk(fifo_count == 5'(sz % 32), req, "fifo_count", fifo_count, sz % 32);
    chk(fifo_full == (sz == 32), req, "fifo_full", fifo_full, sz == 32);
    chk(fifo_empty == (sz == 0), req, "fifo_empty", fifo_empty, sz == 0);
  endtask

  task automatic read_one(input bit irq_chk);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == exp_rd, "R8", "entry value", rd_data, exp_rd);
    if (irq_chk) begin
      @(negedge clk);
      chk(irq == (irq_enable && q.size() >= int'(irq_level)), "R12", "irq level",
          irq, irq_enable && q.size() >= int'(irq_level));
    end
  endtask

  task automatic drain(input bit irq_chk);
    while (q.size() > 0) begin
      read_one(irq_chk);
      check_level("R9");
    end
  endtask

  initial begin
    int base, ack0;
    logic [23:0] s;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy_run && !busy_conv && !busy_wait, "R1", "busy flags", busy_run, 0);
    chk(conv_req == 1'b0, "R1", "conv_req", conv_req, 0);
    chk(fifo_empty && !fifo_full && fifo_count == 0, "R1", "fifo status",
        {fifo_empty, fifo_full, fifo_count}, 7'h40);
    chk(!fifo_overflow && !irq, "R1", "overflow/irq", {fifo_overflow, irq}, 0);
    chk(rd_data == '0, "R1", "rd_data", rd_data, 0);

    // R2 start with engine disabled
    start_pulse = 1'b1;
    @(negedge clk);
    start_pulse = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy_run == 1'b0, "R2", "busy after disabled start", busy_run, 0);
    chk(req_rises == 0, "R2", "requests after disabled start", req_rises, 0);
    eng_enable = 1'b1;

    // R4 R5 R8: single pass over every list length, two slot patterns
    for (int p = 0; p < 2; p++) begin
      s = (p == 0) ? make_slots(5, 3) : make_slots(7, 7);
      for (int last = 0; last < 8; last++) begin
        base = req_rises;
        start_run(s, last, 1'b0, 1, 1'b0);
        wait_idle();
        chk(req_rises - base == last + 1, "R5", "single pass length",
            req_rises - base, last + 1);
        check_level("R9");
        drain(1'b0);
      end
    end

    // R7 delay sweep over both timebases
    for (int tsel = 0; tsel < 2; tsel++) begin
      foreach (delay_count[k]) begin end
      for (int j = 0; j < 4; j++) begin
        int n;
        n = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 3 : 10;
        last_gap = 0;
        start_run(make_slots(3, 1), 1, 1'b0, n, tsel[0]);
        wait_idle();
        chk(last_gap == (n + 1) * (tsel ? PRE : 1), "R7", "request gap",
            last_gap, (n + 1) * (tsel ? PRE : 1));
        drain(1'b0);
      end
    end

    // R5 continuous wrap, R6 stop with nothing more requested
    base = req_rises;
    ack0 = n_ack;
    start_run(make_slots(5, 3), 2, 1'b1, 0, 1'b0);
    while (req_rises - base < 7) @(negedge clk);
    pulse_stop();
    wait_idle();
    chk(req_rises - base >= 7, "R5", "continuous wraps past last slot", req_rises - base, 7);
    chk(n_ack - ack0 == req_rises - base, "R6", "all requests acknowledged",
        n_ack - ack0, req_rises - base);
    base = req_rises;
    repeat (20) @(negedge clk);
    chk(req_rises == base, "R6", "no request after stop", req_rises, base);
    check_level("R9");
    drain(1'b0);

    // R6 stop while a request is outstanding
    lat_cfg = 6;
    base = req_rises;
    ack0 = n_ack;
    start_run(make_slots(1, 0), 7, 1'b0, 2, 1'b0);
    while (req_rises - base < 3) @(negedge clk);
    chk(conv_req == 1'b1, "R6", "request outstanding at stop", conv_req, 1);
    pulse_stop();
    wait_idle();
    repeat (20) @(negedge clk);
    chk(n_ack - ack0 == 3, "R6", "in-flight result completed", n_ack - ack0, 3);
    chk(req_rises - base == 3, "R6", "requests after in-flight stop", req_rises - base, 3);
    chk(fifo_count == 5'd3, "R6", "in-flight result stored", fifo_count, 3);
    drain(1'b0);
    lat_cfg = 2;

    // R6 stop during the delay
    ack0 = n_ack;
    start_run(make_slots(1, 0), 7, 1'b0, 20, 1'b0);
    while (!busy_wait) @(negedge clk);
    chk(busy_wait && !busy_conv, "R3", "busy_wait during delay", busy_wait, 1);
    pulse_stop();
    chk(busy_run == 1'b0, "R6", "run ends on stop in delay", busy_run, 0);
    chk(n_ack - ack0 == 1, "R6", "conversions before delay stop", n_ack - ack0, 1);
    drain(1'b0);

    // R9 R10 fill past capacity
    start_run(make_slots(3, 2), 0, 1'b1, 0, 1'b0);
    while (!fifo_overflow) @(negedge clk);
    repeat (8) @(negedge clk);
    pulse_stop();
    wait_idle();
    chk(q.size() == 32, "R10", "model holds 32", q.size(), 32);
    chk(fifo_full && fifo_count == 5'd0 && !fifo_empty, "R9", "full status",
        {fifo_full, fifo_empty, fifo_count}, 7'h40);
    chk(fifo_overflow == 1'b1, "R10", "sticky overflow", fifo_overflow, 1);

    // R10 push in the same cycle as a read of a full FIFO
    sim_left = 3;
    sim_mode = 1;
    start_run(make_slots(3, 5), 0, 1'b1, 0, 1'b0);
    while (sim_left > 0 || sim_pend) @(negedge clk);
    sim_mode = 0;
    rd_en = 1'b0;
    pulse_stop();
    wait_idle();
    chk(fifo_full == 1'b1, "R10", "full after same-cycle push/read", fifo_full, 1);
    chk(fifo_overflow == 1'b1, "R10", "overflow stays set", fifo_overflow, 1);

    // R12 interrupt over the whole drain
    irq_level = 5'd20;
    irq_enable = 1'b1;
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R12", "irq when full", irq, 1);
    drain(1'b1);

    // R11 read of an empty FIFO
    read_one(1'b0);
    chk(rd_data == '0, "R11", "empty read data", rd_data, 0);
    chk(fifo_count == 0 && fifo_empty, "R11", "count after empty read", fifo_count, 0);

    irq_level = 5'd0;
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R12", "irq threshold zero", irq, 1);
    irq_enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R12", "irq disabled", irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule